// File: doc/BRIEF.md
# Write-Only I2C Master with Self-Terminating Transmit Queue

This block drives an I2C bus as a master that only performs write transfers. Software first loads up to two data bytes into a small transmit queue and then writes the target address. That address write alone launches the transfer with a START condition. The block then shifts out the address byte, with the direction bit forced to write. After that it sends queued bytes, oldest first, for as long as the queue stays non-empty.

At the start of every byte the block checks whether the queue has room. If it does, it raises two status flags and, when enabled, the interrupt line, so that software can top the queue up while the current byte is still on the wire. Once an acknowledged byte completes with the queue empty, the block waits a programmable settling time and ends with a STOP condition without any further command.

A NACK from the slave also ends the transfer with a STOP. It flushes the queue and sets a sticky flag. The SCL high and low phase lengths come from a 16-bit divider register. A slave may hold SCL low to stretch the high phase.

Top module: `i2c_wr_master`

## Requirements
- R1: A write with `reg_sel`=0 (address) while idle starts a transfer. On the next cycle `sda_drive_low` is 1, `scl_drive_low` is 0 (a START condition) and `status[0]` (busy) is 1.
- R2: The first byte on the bus is the address write data with bit 0 forced to 0 (write). The queued bytes follow, oldest first, each MSB first. Queue writes use `reg_sel`=1 and `reg_wdata[7:0]`. The queue holds 2 bytes, and a write to a full queue is dropped.
- R3: SDA changes only while SCL is low. The exceptions are the START edge (SDA falls with SCL high) and the STOP edge (SDA rises with SCL high).
- R4: When SCL first falls in a byte, if the queue is not full, `status[2]` (byte sent) and `status[1]` (room) are set. With two bytes preloaded, no flag appears during the address byte. With one or none preloaded, the flags appear during the address byte.
- R5: After an acknowledged byte, if the queue is empty, the block issues STOP. SCL is released, and SDA is released STOP_GAP+1 clocks after that SCL rise. Busy then clears.
- R6: The divider register (`reg_sel`=2) splits into H=`[15:8]` and L=`[7:0]`. SCL low lasts L+1 clocks and SCL high lasts H+1 clocks. The reset value is 0xCFCF, and L must be at least 2.
- R7: If SDA is high when the ninth clock of a byte is sampled (NACK), `status[3]` is set, STOP follows, and the queue is flushed. A later transfer then sends only its address.
- R8: An address write while busy is ignored. No second START occurs and the byte in flight is unchanged.
- R9: A `stat_rd` pulse clears `status[3:1]`. A queue write clears `status[2:1]`. A flag set in the same cycle as a clear wins.
- R10: `irq` is high exactly when the enable bit is set and any of `status[3:1]` is set. The enable bit is `reg_wdata[0]` of a `reg_sel`=3 write.
- R11: While the block has released SCL but samples it low (clock stretching), the high-phase count is frozen.
- R12: After reset both lines are released, `status` is 0, `irq` is 0 and the interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 queue data, 2 divider, 3 control |
| reg_wdata | input | DIV_W | Register write data |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| status | output | 4 | {nack, sent, room, busy} |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions take `scl_in` and `sda_in` as already synchronous to `clk`. They also assume the slave moves SDA only while SCL is low. Under these conditions the master's own hold of SDA through each high phase, and its ACK sampling, are well defined. The bench builds the bus as a wired-AND of the block's drive outputs and a slave model. The slave changes its ACK drive and its stretch hold only on a falling SCL edge, and every divider setting it uses has a low count of at least 3.

// File: rtl/i2cw_pkg.sv
// Shared types for the write-only I2C master.
// Assumes: nothing beyond a 2-bit register select.
package i2cw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_FREE
    } eng_state_t;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIV  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/i2cw_txfifo.sv
// Small transmit queue: first in, first out, with a synchronous flush.
// Assumes: a push to a full queue is dropped; a pop of an empty queue is ignored.
module i2cw_txfifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Storage write; the contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && !do_pop && !flush) |=> (count == $past(count) + 1'b1)); // R2
endmodule

// File: rtl/i2cw_phase_timer.sv
// Down-counter that times one SCL phase; freezes while told to hold.
// Assumes: load has priority over hold; done means the count has reached zero.
module i2cw_phase_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          hold,
    output logic          done
);
    logic [TW-1:0] cnt;

    assign done = (cnt == '0);

    // Load a new phase length, otherwise count down unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (!hold && cnt != 0) cnt <= cnt - 1'b1;
    end

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load) |=> $stable(cnt)); // R11
endmodule

// File: rtl/i2c_wr_master.sv
// Write-only I2C master. An address write launches START, the address byte
// and the queued bytes. The transfer stops by itself once the queue is empty
// after an ACK, or at once on a NACK.
// Assumes: scl_in/sda_in are synchronous to clk; divider low count >= 2.
module i2c_wr_master
    import i2cw_pkg::*;
#(
    parameter int              DIV_W     = 16,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'hCFCF,
    parameter int              STOP_GAP  = 1020,
    parameter int              DEPTH     = 2,
    parameter int              TW        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [DIV_W-1:0] reg_wdata,
    input  logic             stat_rd,
    output logic [3:0]       status,
    output logic             irq,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low
);
    localparam int HALF_W = DIV_W / 2;
    localparam logic [3:0] ACK_BIT = 4'd8;

    eng_state_t       state, state_n;
    logic [DIV_W-1:0] div_q;
    logic             irq_en;
    logic [3:1]       stat_q;
    logic [7:0]       shreg;
    logic [3:0]       bitn;
    logic             pend, bb, bb_q;
    logic             addr_wr, fifo_push, pop, flush, nack_set;
    logic             fifo_empty, fifo_full;
    logic [7:0]       fifo_dout;
    logic             tload, tdone, t_hold, step;
    logic [TW-1:0]    tval, hi_cnt, lo_cnt;

    assign addr_wr   = reg_wr && (reg_sel == SEL_ADDR);
    assign fifo_push = reg_wr && (reg_sel == SEL_DATA);
    assign hi_cnt    = TW'(div_q[DIV_W-1:HALF_W]);
    assign lo_cnt    = TW'(div_q[HALF_W-1:0]);
    assign t_hold    = (state == ST_HIGH || state == ST_STOP_HIGH) && !scl_in;
    assign step      = tdone && !t_hold;
    assign status    = {stat_q, (state != ST_IDLE)};
    assign irq       = irq_en && (|stat_q);

    i2cw_txfifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(reg_wdata[7:0]),
        .pop(pop), .flush(flush), .dout(fifo_dout),
        .empty(fifo_empty), .full(fifo_full)
    );

    i2cw_phase_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval),
        .hold(t_hold), .done(tdone)
    );

    // Next-state decision, phase timer reload, queue pop/flush and byte-start pulse.
    always_comb begin
        state_n  = state;
        tload    = 1'b0;
        tval     = '0;
        pop      = 1'b0;
        flush    = 1'b0;
        bb       = 1'b0;
        nack_set = 1'b0;
        case (state)
            ST_IDLE:
                if (addr_wr) begin state_n = ST_START; tload = 1'b1; tval = hi_cnt; end
            ST_START:
                if (step) begin state_n = ST_LOW; tload = 1'b1; tval = lo_cnt; bb = 1'b1; end
            ST_LOW:
                if (step) begin state_n = ST_HIGH; tload = 1'b1; tval = hi_cnt; end
            ST_HIGH:
                if (step) begin
                    tload = 1'b1;
                    tval  = lo_cnt;
                    if (bitn != ACK_BIT) begin
                        state_n = ST_LOW;
                    end else if (sda_in) begin
                        state_n  = ST_STOP_LOW;
                        nack_set = 1'b1;
                        flush    = 1'b1;
                    end else if (fifo_empty) begin
                        state_n = ST_STOP_LOW;
                    end else begin
                        state_n = ST_LOW;
                        pop     = 1'b1;
                        bb      = 1'b1;
                    end
                end
            ST_STOP_LOW:
                if (step) begin state_n = ST_STOP_HIGH; tload = 1'b1; tval = TW'(STOP_GAP); end
            ST_STOP_HIGH:
                if (step) begin state_n = ST_FREE; tload = 1'b1; tval = hi_cnt; end
            ST_FREE:
                if (step) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Bus drivers, shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            scl_drive_low <= 1'b0;
            sda_drive_low <= 1'b0;
            shreg         <= '0;
            bitn          <= '0;
            pend          <= 1'b0;
            bb_q          <= 1'b0;
        end else begin
            state <= state_n;
            bb_q  <= bb;
            case (state)
                ST_IDLE:
                    if (addr_wr) begin
                        sda_drive_low <= 1'b1;
                        shreg         <= {reg_wdata[7:1], 1'b0};
                    end
                ST_START:
                    if (step) begin
                        scl_drive_low <= 1'b1;
                        pend          <= !shreg[7];
                        bitn          <= '0;
                    end
                ST_LOW, ST_STOP_LOW: begin
                    sda_drive_low <= pend;
                    if (step) scl_drive_low <= 1'b0;
                end
                ST_HIGH:
                    if (step) begin
                        scl_drive_low <= 1'b1;
                        if (bitn != ACK_BIT) begin
                            bitn  <= bitn + 1'b1;
                            shreg <= {shreg[6:0], 1'b0};
                            pend  <= (bitn == 4'd7) ? 1'b0 : !shreg[6];
                        end else if (sda_in || fifo_empty) begin
                            pend <= 1'b1;
                        end else begin
                            shreg <= fifo_dout;
                            bitn  <= '0;
                            pend  <= !fifo_dout[7];
                        end
                    end
                ST_STOP_HIGH:
                    if (step) sda_drive_low <= 1'b0;
                default: ;
            endcase
        end
    end

    // Configuration registers and sticky status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_RESET;
            irq_en <= 1'b0;
            stat_q <= '0;
        end else begin
            if (reg_wr && reg_sel == SEL_DIV)  div_q  <= reg_wdata;
            if (reg_wr && reg_sel == SEL_CTRL) irq_en <= reg_wdata[0];
            if (stat_rd)   stat_q      <= '0;
            if (fifo_push) stat_q[2:1] <= '0;
            if (bb_q && !fifo_full) stat_q[2:1] <= 2'b11;
            if (nack_set)  stat_q[3]   <= 1'b1;
        end
    end

    AST_START_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> (sda_drive_low && !scl_drive_low)); // R1
    AST_SDA_STILL_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(sda_drive_low)); // R3
    AST_FLAG_AT_BYTE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[2]) |-> $past(bb_q)); // R4
    AST_STOP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && step && bitn == ACK_BIT && !sda_in && fifo_empty)
            |=> (state == ST_STOP_LOW)); // R5
    AST_NACK_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        nack_set |=> (fifo_empty && stat_q[3])); // R7
    AST_BUSY_IGNORES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && state != ST_IDLE && state != ST_START) |=> (state != ST_START)); // R8
endmodule

// File: tb/i2c_wr_master_test.sv
`timescale 1ns/100ps
module i2c_wr_master_test;
    localparam int GAP = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        stat_rd = 1'b0;
    logic [3:0]  status;
    logic        irq, scl_drive_low, sda_drive_low;
    logic        stretch = 1'b0, ack_drv = 1'b0, ack_en = 1'b1;
    wire         scl_line = !(scl_drive_low || stretch);
    wire         sda_line = !(sda_drive_low || ack_drv);

    int nchk = 0, nfail = 0;
    int bc = 0, ngot = 0, starts = 0, stops = 0, ntx = 0;
    int meas_low = 0, meas_high = 0, stop_gap = 0;
    logic        in_frame = 1'b0;
    logic [7:0]  sh = '0;
    logic [7:0]  got [8];
    realtime     t_rise = 0, t_fall = 0, t_rel = 0;

    i2c_wr_master #(.STOP_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_rd(stat_rd), .status(status), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    always #2.5 clk = !clk;

    function automatic int ns2cyc(input realtime d);
        return int'(d / 5.0);
    endfunction

    // Slave model: START/STOP detection, bit capture, ACK drive, phase timing.
    always @(negedge sda_line) if (rst_n === 1'b1 && scl_line === 1'b1) begin
        starts++; in_frame = 1'b1; bc = 0;
    end
    always @(posedge sda_line) if (rst_n === 1'b1 && scl_line === 1'b1 && in_frame) begin
        stops++; in_frame = 1'b0; stop_gap = ns2cyc($realtime - t_rise);
    end
    always @(posedge scl_line) if (in_frame) begin
        t_rise = $realtime;
        if (bc == 0) meas_low = ns2cyc(t_rise - t_fall);
        if (bc < 8) begin
            sh = {sh[6:0], sda_line}; bc++;
            if (bc == 8) begin if (ngot < 8) got[ngot] = sh; ngot++; end
        end else if (bc == 8) bc = 9;
    end
    always @(negedge scl_line) if (in_frame) begin
        t_fall = $realtime;
        if (bc == 1) meas_high = ns2cyc(t_fall - t_rise);
        if (bc == 8) ack_drv = ack_en;
        else if (bc == 9) begin ack_drv = 1'b0; bc = 0; end
    end

    task automatic check(input int act, input int exp, input string req);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rdstat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic launch(input logic [7:0] a);
        if (status[0] == 1'b0) ntx++;
        wr(2'd0, {8'h00, a});
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!status[0]) break;
        end
    endtask

    task automatic scl_rises(input int n);
        repeat (n) @(posedge scl_line);
        @(negedge clk);
    endtask

    // Vectors: {addr, preload count, d0, d1, high count, low count}
    localparam int NV = 4;
    localparam logic [41:0] VEC [NV] = '{
        {8'hA0, 2'd2, 8'h11, 8'h22, 8'd6, 8'd5},
        {8'h5B, 2'd1, 8'hC3, 8'h00, 8'd3, 8'd4},
        {8'h3C, 2'd0, 8'h00, 8'h00, 8'd4, 8'd3},
        {8'hFF, 2'd2, 8'h00, 8'hFF, 8'd8, 8'd3}
    };

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(status, 0, "R12 status");
        check(irq, 0, "R12 irq");
        check({scl_drive_low, sda_drive_low}, 0, "R12 lines released");

        // Vector walk: R2 byte content, R5 stop gap, R6 phase lengths
        for (int v = 0; v < NV; v++) begin
            logic [41:0] e;
            e = VEC[v];
            ngot = 0;
            wr(2'd2, e[15:0]);
            if (e[33:32] > 0) wr(2'd1, {8'h00, e[31:24]});
            if (e[33:32] > 1) wr(2'd1, {8'h00, e[23:16]});
            launch(e[41:34]);
            check(status[0], 1, "R1 busy after address write");
            check(sda_drive_low && !scl_drive_low, 1, "R1 START shape");
            wait_idle();
            check(ngot, int'(e[33:32]) + 1, "R2 byte count");
            check(got[0], {e[41:35], 1'b0}, "R2 address byte with write bit");
            if (e[33:32] > 0) check(got[1], e[31:24], "R2 first data byte");
            if (e[33:32] > 1) check(got[2], e[23:16], "R2 second data byte");
            check(meas_low, int'(e[7:0]) + 1, "R6 low phase");
            check(meas_high, int'(e[15:8]) + 1, "R6 high phase");
            check(stop_gap, GAP + 1, "R5 stop gap");
            check(status[0], 0, "R5 busy cleared");
        end

        // R4/R9/R10: flag timing with two bytes preloaded, then top-up
        wr(2'd2, 16'h0605);
        rdstat();
        wr(2'd3, 16'h0001);
        ngot = 0;
        wr(2'd1, 16'h0011);
        wr(2'd1, 16'h0022);
        wr(2'd1, 16'h0033); // R2: dropped, queue full
        launch(8'hA0);
        scl_rises(3);
        check(status[2], 0, "R4 no flag in address with full queue");
        check(irq, 0, "R10 irq low without flags");
        wait (ngot == 1);
        scl_rises(3);
        check(status[2:1], 2'b11, "R4 flags on first data byte");
        check(irq, 1, "R10 irq with flags enabled");
        wr(2'd1, 16'h0044);
        check(status[2:1], 2'b00, "R9 queue write clears flags");
        check(irq, 0, "R10 irq drops with flags");
        wait (ngot == 2);
        scl_rises(3);
        check(status[2], 1, "R4 flag on second data byte");
        rdstat();
        check(status[3:1], 0, "R9 read clears flags");
        wait_idle();
        check(ngot, 4, "R2 top-up byte sent, overflow dropped");
        check(got[3], 8'h44, "R2 top-up byte value");

        // R4: one byte preloaded flags during the address byte
        rdstat();
        wr(2'd1, 16'h0055);
        launch(8'hA0);
        scl_rises(3);
        check(status[2:1], 2'b11, "R4 flag in address with one byte");
        wr(2'd3, 16'h0000);
        check(irq, 0, "R10 irq disabled");
        wait_idle();

        // R8: address write while busy ignored
        ngot = 0;
        wr(2'd1, 16'h005A);
        launch(8'hA0);
        scl_rises(2);
        launch(8'h70);
        wait_idle();
        check(ngot, 2, "R8 byte count unchanged");
        check(got[0], 8'hA0, "R8 address not replaced");

        // R7: NACK on address flushes queue
        ack_en = 1'b0;
        ngot = 0;
        rdstat();
        wr(2'd1, 16'h0066);
        wr(2'd1, 16'h0077);
        launch(8'hB0);
        wait_idle();
        check(status[3], 1, "R7 nack flag");
        check(ngot, 1, "R7 stop after address");
        ack_en = 1'b1;
        rdstat();
        check(status[3], 0, "R9 read clears nack");
        ngot = 0;
        launch(8'hB0);
        wait_idle();
        check(ngot, 1, "R7 queue flushed");

        // R11: clock stretching freezes the high-phase count (high = 6)
        ngot = 0;
        wr(2'd1, 16'h0081);
        launch(8'hC0);
        repeat (2) @(posedge scl_line);
        @(negedge scl_line);
        stretch = 1'b1;
        repeat (40) @(negedge clk);
        stretch = 1'b0;
        t_rel = $realtime;
        @(negedge scl_line);
        check(($realtime - t_rel) >= 30.0, 1, "R11 high phase after stretch");
        wait_idle();
        check(got[1], 8'h81, "R11 data intact after stretch");

        // R3: every SDA edge with SCL high was a START or STOP of a transfer
        check(starts, ntx, "R3 START count");
        check(stops, ntx, "R3 STOP count");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule